// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous request port inside the chip and an external asynchronous static RAM of 2M bytes. Each accepted request is one single-beat read or write. The controller turns it into a complete strobe sequence on the memory pins, then returns a one-cycle response. Every pulse width and gap on the memory side is derived from nanosecond limits. A parameter holds the clock period, and each limit is rounded up to a whole number of clock cycles.

The memory is selected by a pair of enables of opposite polarity: an active-low enable and an active-high enable. These always move together. They are left deselected whenever no access is running, so the memory falls into standby. After reset the controller holds off all traffic for a power-up interval. The shared data bus is only driven by the controller inside a write, and only once any read data the memory may still be driving has had time to float away.

The request port follows valid/ready rules. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and the fields are copied at that edge. The requester must hold its fields while valid is high and ready is low. It may change them freely after the transfer. `req_ready` stays low through the whole access and through the response cycle, so one access at a time is in flight. The response has no back-pressure: `rsp_valid` is high for exactly one cycle per request, and the requester must take it then.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the memory is deselected (`sram_ce1_n`=1, `sram_ce2`=0), `sram_we_n`=1, `sram_oe_n`=1, `req_ready`=0 and `rsp_valid`=0.
- R2: After reset is released, `req_ready` stays low and the memory stays deselected for PWR_CYC = ceil(T_PWRUP_NS/CLK_NS) cycles (50000 by default); `req_ready` rises on the cycle after that.
- R3: A read holds the memory selected with `sram_oe_n`=0 and `sram_we_n`=1 for exactly RD_CYC cycles. RD_CYC is the round-up of the largest of the read cycle, address access, enable access and output-enable access limits (12 by default). `rsp_valid` appears RD_CYC cycles after the accepting edge, carrying in `rsp_rdata` the byte the memory presented at the end of the strobe.
- R4: A write drives `sram_we_n` low for exactly WE_CYC cycles, the round-up of the larger of the pulse-width and address-to-end limits (9 by default). The memory is selected throughout, and the byte written is `req_wdata` from the accepting edge.
- R5: `sram_we_n` falls no earlier than HZ_CYC+1 cycles after the most recent rise of `sram_oe_n`, where HZ_CYC = ceil(18 ns/CLK_NS) (5 by default). The controller's bus drive therefore starts at least HZ_CYC cycles after the memory's output was disabled.
- R6: `req_ready` is low from the accepting edge until the cycle after the response. Each request yields exactly one `rsp_valid` pulse of one cycle.
- R7: Whenever `req_ready` is high, the memory is deselected.
- R8: `sram_we_n` and `sram_oe_n` are never low in the same cycle. `sram_oe_n` stays high for the whole of a write.
- R9: `sram_addr` does not change while the memory stays selected, even if `req_addr` changes after the request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (21) | Byte address |
| req_wdata | input | DW (8) | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW (8) | Read byte, valid with rsp_valid after a read |
| sram_ce1_n | output | 1 | Active-low memory enable |
| sram_ce2 | output | 1 | Active-high memory enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_addr | output | AW (21) | Memory address |
| sram_dq | inout | DW (8) | Bidirectional data bus |

## Verification
A sequencer stuck in, or skipping, a state shows on the memory pins within the access it corrupts. The output-enable or write-strobe low time comes out longer or shorter than RD_CYC or WE_CYC, or the response arrives on the wrong cycle. A turnaround counter loaded with too small a value shows only on the first write after a read, as a write strobe falling fewer than HZ_CYC+1 cycles after output enable rose. A broken power-up counter shows as `req_ready` rising on the wrong cycle after reset. A wrongly latched address or byte shows when a later read returns a value the request stream never wrote there.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WGAP,
    ST_WSET,
    ST_WPULSE,
    ST_WREC
  } seq_state_t;

  // Round a nanosecond limit up to whole clock periods.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // A load of N must keep the counter non-zero for N cycles.
  p_load_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/sram_powerup_hold.sv
module sram_powerup_hold #(
  parameter int CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int W = (CYC < 1) ? 1 : $clog2(CYC + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= W'(CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int AW = 21,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  // Request fields are copied only while no access is in flight.
  p_no_latch_on_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && capture));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 12,
  parameter int WE_CYC   = 9,
  parameter int REC_CYC  = 2,
  parameter int GAP_LOAD = 4,
  parameter int TW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          pwr_done,
  input  logic          tmr_zero,
  input  logic          gap_zero,
  output logic          req_ready,
  output logic          accept,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          gap_load,
  output logic [TW-1:0] gap_val,
  output logic          capture,
  output logic          sel_q,
  output logic          we_n_q,
  output logic          oe_n_q,
  output logic          drive_q,
  output logic          rsp_valid_q
);
  seq_state_t state_q, state_d;
  logic       rsp_set;

  assign req_ready = (state_q == ST_IDLE) && pwr_done && !rsp_valid_q;
  assign accept    = req_valid && req_ready;
  assign gap_val   = TW'(GAP_LOAD);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    gap_load = 1'b0;
    capture  = 1'b0;
    rsp_set  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            state_d = ST_WGAP;
          end else begin
            state_d  = ST_RD;
            tmr_load = 1'b1;
            tmr_val  = TW'(RD_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (tmr_zero) begin
          state_d  = ST_IDLE;
          capture  = 1'b1;
          gap_load = 1'b1;
          rsp_set  = 1'b1;
        end
      end
      ST_WGAP: begin
        if (gap_zero) state_d = ST_WSET;
      end
      ST_WSET: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = TW'(WE_CYC - 1);
      end
      ST_WPULSE: begin
        if (tmr_zero) begin
          state_d  = ST_WREC;
          tmr_load = 1'b1;
          tmr_val  = TW'(REC_CYC - 1);
        end
      end
      ST_WREC: begin
        if (tmr_zero) begin
          state_d = ST_IDLE;
          rsp_set = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state: same timing as a state
  // decode, but free of decode glitches on the memory pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sel_q       <= 1'b0;
      we_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      drive_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      sel_q       <= (state_d != ST_IDLE);
      we_n_q      <= (state_d != ST_WPULSE);
      oe_n_q      <= (state_d != ST_RD);
      drive_q     <= (state_d == ST_WSET) || (state_d == ST_WPULSE);
      rsp_valid_q <= rsp_set;
    end
  end

  // Run-length counters used only by the width checks below.
  logic [15:0] we_run_q, oe_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run_q <= '0;
      oe_run_q <= '0;
    end else begin
      we_run_q <= we_n_q ? 16'd0 : we_run_q + 16'd1;
      oe_run_q <= oe_n_q ? 16'd0 : oe_run_q + 16'd1;
    end
  end

  p_we_oe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_q && !oe_n_q));
  p_drive_oe_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q |-> oe_n_q);
  p_we_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> sel_q);
  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (we_run_q == 16'(WE_CYC)));
  p_rd_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n_q) |-> (oe_run_q == 16'(RD_CYC)));
  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |=> !rsp_valid_q);
  p_ack_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |-> !sel_q);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW         = 21,
  parameter int DW         = 8,
  parameter int CLK_NS     = 4,
  parameter int T_RC_NS    = 45,
  parameter int T_AA_NS    = 45,
  parameter int T_ACE_NS   = 45,
  parameter int T_DOE_NS   = 22,
  parameter int T_WC_NS    = 45,
  parameter int T_PWE_NS   = 35,
  parameter int T_AW_NS    = 35,
  parameter int T_SD_NS    = 25,
  parameter int T_HZ_NS    = 18,
  parameter int T_PWRUP_NS = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  inout  wire  [DW-1:0] sram_dq
);
  localparam int RD_CYC = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                               imax(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)));
  // Data is driven one cycle ahead of the strobe, so setup needs one cycle less.
  localparam int WE_CYC = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                               imax(1, ns_to_cyc(T_SD_NS, CLK_NS) - 1));
  localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int REC_CYC  = imax(1, WC_CYC - WE_CYC - 1);
  localparam int HZ_CYC   = imax(1, ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int GAP_LOAD = HZ_CYC - 1;
  localparam int PWR_CYC  = imax(1, ns_to_cyc(T_PWRUP_NS, CLK_NS));
  localparam int TW = $clog2(imax(imax(RD_CYC, WE_CYC), imax(REC_CYC, HZ_CYC)) + 1);

  logic          pwr_done, tmr_zero, gap_zero, accept;
  logic          tmr_load, gap_load, capture;
  logic [TW-1:0] tmr_val, gap_val;
  logic          sel_q, drive_q;
  logic [DW-1:0] wdata_q, dq_in;

  sram_powerup_hold #(.CYC(PWR_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .done(pwr_done)
  );

  sram_cycle_timer #(.W(TW)) u_strobe_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sram_cycle_timer #(.W(TW)) u_gap_tmr (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .REC_CYC(REC_CYC), .GAP_LOAD(GAP_LOAD), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .pwr_done(pwr_done), .tmr_zero(tmr_zero), .gap_zero(gap_zero),
    .req_ready(req_ready), .accept(accept), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .gap_load(gap_load), .gap_val(gap_val), .capture(capture), .sel_q(sel_q),
    .we_n_q(sram_we_n), .oe_n_q(sram_oe_n), .drive_q(drive_q), .rsp_valid_q(rsp_valid)
  );

  sram_data_path #(.AW(AW), .DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture), .dq_in(dq_in),
    .addr_q(sram_addr), .wdata_q(wdata_q), .rdata_q(rsp_rdata)
  );

  assign sram_ce1_n = !sel_q;
  assign sram_ce2   = sel_q;
  assign sram_dq    = drive_q ? wdata_q : {DW{1'bz}};
  assign dq_in      = sram_dq;

  p_hold_powerup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |-> (sram_ce1_n && !sram_ce2));
  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_q) |-> gap_zero);
  p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && !sram_ce2));
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce1_n && $past(!sram_ce1_n)) |-> $stable(sram_addr));
endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int CLK_NS = 4;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int X_RD  = (45 + CLK_NS - 1) / CLK_NS;
  localparam int X_WE  = (35 + CLK_NS - 1) / CLK_NS;
  localparam int X_HZ  = (18 + CLK_NS - 1) / CLK_NS;
  localparam int X_PWR = (200000 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n;
  logic [AW-1:0] sram_addr;
  wire  [DW-1:0] dq;

  logic          model_en = 1'b0;
  logic [DW-1:0] model_q  = '0;
  assign dq = model_en ? model_q : {DW{1'bz}};

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_ce1_n(sram_ce1_n),
    .sram_ce2(sram_ce2), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_dq(dq)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mem     [int];
  logic [7:0] ref_mem [int];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(input logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  // Memory model and pin monitor, both acting away from the rising edge.
  int cyc = 0, last_oe_rise = -1, we_run = 0, oe_run = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_sel = 1'b0, addr_moved = 1'b0;
  logic [AW-1:0] prev_addr = '0, waddr = '0;
  logic [DW-1:0] wlat = '0;

  always @(negedge clk) begin
    logic sel;
    cyc++;
    sel = !sram_ce1_n && sram_ce2;
    if (rst_n) begin
      if (!sram_we_n && prev_we) begin
        if (last_oe_rise >= 0)
          chk(cyc - last_oe_rise >= X_HZ + 1, "R5 oe-rise to we-fall gap", cyc - last_oe_rise, X_HZ + 1);
        chk(sram_oe_n && sel, "R8 oe high and selected at write", {sram_oe_n, sel}, 2'b11);
      end
      if (sram_we_n && !prev_we) begin
        chk(we_run == X_WE, "R4 write strobe width", we_run, X_WE);
        mem[int'(waddr)] = wlat;
      end
      if (sram_oe_n && !prev_oe) begin
        chk(oe_run == X_RD, "R3 read strobe width", oe_run, X_RD);
        last_oe_rise = cyc;
      end
      if (!sram_we_n && !sram_oe_n) chk(1'b0, "R8 we and oe both low", 0, 1);
      if (req_ready) chk(sram_ce1_n && !sram_ce2, "R7 deselected when ready", {sram_ce1_n, sram_ce2}, 2'b10);
      if (sel && prev_sel && sram_addr != prev_addr) addr_moved = 1'b1;
      if (!sel && prev_sel) begin
        chk(!addr_moved, "R9 address held while selected", addr_moved, 0);
        addr_moved = 1'b0;
      end
      if (sel && !sram_we_n) begin
        wlat  = dq;
        waddr = sram_addr;
      end
    end
    we_run    = sram_we_n ? 0 : we_run + 1;
    oe_run    = sram_oe_n ? 0 : oe_run + 1;
    prev_we   = sram_we_n;
    prev_oe   = sram_oe_n;
    prev_sel  = sel;
    prev_addr = sram_addr;
    model_en  = sel && !sram_oe_n && sram_we_n;
    model_q   = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit now);
    int n;
    bit ready_seen;
    if (!now) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = AW'($urandom);
    req_wdata = DW'($urandom);
    n = 1;
    ready_seen = 1'b0;
    while (!rsp_valid && n < 200) begin
      if (req_ready) ready_seen = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(rsp_valid && !req_ready && !ready_seen, "R6 busy until one response", {rsp_valid, req_ready, ready_seen}, 3'b100);
    if (!wr) begin
      chk(n == X_RD + 1, "R3 read response latency", n, X_RD + 1);
      chk(rsp_rdata == ref_byte(a), "R3 R4 read data", rsp_rdata, ref_byte(a));
    end else begin
      ref_mem[int'(a)] = d;
    end
    @(negedge clk);
    chk(!rsp_valid, "R6 response one cycle", rsp_valid, 0);
  endtask

  bit done_flag = 1'b0;
  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [AW-1:0] pool [12];
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n, "R1 strobes idle in reset",
        {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n}, 4'b1011);
    chk(!req_ready && !rsp_valid, "R1 handshake idle in reset", {req_ready, rsp_valid}, 0);
    rst_n = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 21'h12345; req_wdata = 8'hEE;
    @(negedge clk);
    chk(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n, "R1 strobes idle after reset",
        {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n}, 4'b1011);
    repeat (X_PWR - 2) @(posedge clk);
    @(negedge clk);
    chk(!req_ready, "R2 ready low at end of power-up wait", req_ready, 0);
    chk(sram_ce1_n, "R2 no access during power-up", sram_ce1_n, 1);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready, "R2 ready after power-up wait", req_ready, 1);

    // Directed corners: extreme addresses, unwritten read, turnarounds.
    do_req(1'b1, 21'h000000, 8'hA5, 1'b0);
    do_req(1'b1, 21'h1FFFFF, 8'h3C, 1'b1);
    do_req(1'b0, 21'h000000, 8'h00, 1'b1);
    do_req(1'b1, 21'h000000, 8'h5A, 1'b1);   // R5 minimum read-to-write gap
    do_req(1'b0, 21'h1FFFFF, 8'h00, 1'b0);
    do_req(1'b0, 21'h000ABC, 8'h00, 1'b1);   // never written: reads 00
    do_req(1'b0, 21'h000000, 8'h00, 1'b1);
    do_req(1'b1, 21'h1FFFFF, 8'hC3, 1'b1);   // overwrite
    do_req(1'b0, 21'h1FFFFF, 8'h00, 1'b1);

    foreach (pool[i]) pool[i] = AW'($urandom);
    pool[0] = 21'h000000;
    pool[1] = 21'h1FFFFF;
    for (int k = 0; k < 300; k++) begin
      bit wr, now;
      logic [AW-1:0] a;
      wr  = ($urandom % 2) == 0;
      now = ($urandom % 3) == 0;
      a   = pool[$urandom % 12];
      do_req(wr, a, DW'($urandom), now);
    end
    finish_run();
  end
endmodule